// File: doc/BRIEF.md
# Guest Event Injection Word Encoder

This block runs when a guest is active and an exception or software interrupt has to be handed to it. On a start pulse it captures the event (vector, software-interrupt flag, error code, real-mode flag) and reads the current event-injection word through a one-cycle register read port. If that word already holds a pending event, the block writes nothing and finishes. Otherwise it composes a fresh injection word and, where the vector calls for it, an error-code word. It then writes both through two write strobes.

The error code is attached only when the processor is outside real mode and the vector belongs to the fixed set of vectors that push an error code. When both words are written, they are written in the same cycle. The valid bit therefore never becomes visible ahead of its error code. Delivering the event to the guest is handled elsewhere.

Top module: `evinj_encoder`

## Requirements
- R1: A start accepted while idle (busy low) raises rd_en for exactly one cycle, in the cycle after the start edge, and no write strobe is asserted before that read has returned.
- R2: If bit 31 of the word read back is set, neither inj_we nor err_we is asserted for that request, and done still pulses.
- R3: The 3-bit type field at bits 10:8 of the new word is 4 when sw_int was high at start, and 3 otherwise.
- R4: The new injection word carries the vector in bits 7:0, the type in bits 10:8, bit 31 set, and zeros in every other bit except bit 11.
- R5: When real_mode was low and the vector is 8, 10, 11, 12, 13, 14, 17 or 21, bit 11 of the new word is set. err_we is asserted in the same cycle as inj_we with err_wdata equal to the captured error code. This holds regardless of sw_int.
- R6: When real_mode was high, err_we stays low and bit 11 is clear, for every vector.
- R7: Any vector outside the set of R5, including every vector of 32 and above, gives err_we low and bit 11 clear.
- R8: done pulses for exactly one cycle, three cycles after the start edge, together with any write strobes. A start while busy is ignored.
- R9: While reset is applied, and for two cycles after its release, rd_en, inj_we, err_we, done and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse; inputs below are captured with it |
| vector | input | 8 | Event vector number |
| sw_int | input | 1 | Event came from an interrupt instruction |
| err_code | input | 32 | Error code for vectors that push one |
| real_mode | input | 1 | Processor is in real mode |
| rd_en | output | 1 | Read request for the current injection word |
| rd_data | input | 32 | Injection word, valid the cycle after rd_en |
| inj_we | output | 1 | Write strobe for the injection word |
| inj_wdata | output | 32 | New injection word |
| err_we | output | 1 | Write strobe for the error-code word |
| err_wdata | output | 32 | Error-code word |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A request is in progress |

## Verification
The bench aims at the boundaries of the error-vector set: 8 versus 9, 21, 17, a software interrupt on vector 13, and vector 45. Vector 45 shares its low five bits with 13, so a lookup that drops the upper vector bits would wrongly attach an error code there. Real-mode requests on error vectors catch a design that ignores the mode and writes the error word anyway. A pending word with bit 31 set, and a non-pending word with junk in its low bits, expose a design that either overwrites a queued event or tests the wrong bit. A second start during a request and a reset in mid-request show whether the block can double-write or leak a strobe after reset.

// File: rtl/evinj_pkg.sv
package evinj_pkg;
  // Field layout of the injection word; neighbours decode these positions.
  localparam int TYPE_LSB  = 8;
  localparam int TYPE_W    = 3;
  localparam int ERRV_BIT  = 11;
  localparam int VALID_BIT = 31;

  localparam logic [TYPE_W-1:0] TYPE_EXCEPTION = 3'd3;
  localparam logic [TYPE_W-1:0] TYPE_SOFT_INT  = 3'd4;

  // Bit n set means vector n pushes an error code.
  localparam logic [31:0] ERR_VEC_MASK_DEF = 32'h0022_7D00;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_CHECK = 2'd2,
    ST_EMIT  = 2'd3
  } evinj_state_t;
endpackage

// File: rtl/evinj_errvec_lut.sv
module evinj_errvec_lut #(
  parameter int          VEC_W    = 8,
  parameter logic [31:0] ERR_MASK = evinj_pkg::ERR_VEC_MASK_DEF
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic             has_err_o
);
  localparam int LUT_N = 32;
  localparam int IDX_W = $clog2(LUT_N);

  logic             in_range;
  logic [IDX_W-1:0] idx;

  generate
    if (VEC_W > IDX_W) begin : g_wide
      assign in_range = ~|vec_i[VEC_W-1:IDX_W];
      assign idx      = vec_i[IDX_W-1:0];
    end else begin : g_narrow
      assign in_range = 1'b1;
      assign idx      = IDX_W'(vec_i);
    end
  endgenerate

  assign has_err_o = in_range & ERR_MASK[idx];
endmodule

// File: rtl/evinj_word_build.sv
module evinj_word_build #(
  parameter int VEC_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              soft_i,
  input  logic              attach_err_i,
  output logic [WORD_W-1:0] word_o
);
  import evinj_pkg::*;

  always_comb begin
    word_o                      = '0;
    word_o[VEC_W-1:0]           = vec_i;
    word_o[TYPE_LSB +: TYPE_W]  = soft_i ? TYPE_SOFT_INT : TYPE_EXCEPTION;
    word_o[ERRV_BIT]            = attach_err_i;
    word_o[VALID_BIT]           = 1'b1;
  end
endmodule

// File: rtl/evinj_ctrl.sv
module evinj_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic capture_req_o,
  output logic capture_old_o,
  output logic rd_en_o,
  output logic emit_o,
  output logic busy_o
);
  import evinj_pkg::*;

  evinj_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_READ;
      ST_READ:  state_d = ST_CHECK;
      ST_CHECK: state_d = ST_EMIT;
      ST_EMIT:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign capture_req_o = (state_q == ST_IDLE) && start_i;
  assign rd_en_o       = (state_q == ST_READ);
  assign capture_old_o = (state_q == ST_CHECK);
  assign emit_o        = (state_q == ST_EMIT);
  assign busy_o        = (state_q != ST_IDLE);
endmodule

// File: rtl/evinj_encoder.sv
module evinj_encoder #(
  parameter int          VEC_W    = 8,
  parameter int          ERR_W    = 32,
  parameter int          WORD_W   = 32,
  parameter logic [31:0] ERR_MASK = evinj_pkg::ERR_VEC_MASK_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VEC_W-1:0]  vector,
  input  logic              sw_int,
  input  logic [ERR_W-1:0]  err_code,
  input  logic              real_mode,
  output logic              rd_en,
  input  logic [WORD_W-1:0] rd_data,
  output logic              inj_we,
  output logic [WORD_W-1:0] inj_wdata,
  output logic              err_we,
  output logic [ERR_W-1:0]  err_wdata,
  output logic              done,
  output logic              busy
);
  import evinj_pkg::*;

  localparam int SYNC_N = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  logic capture_req, capture_old, emit;

  evinj_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start_i       (start),
    .capture_req_o (capture_req),
    .capture_old_o (capture_old),
    .rd_en_o       (rd_en),
    .emit_o        (emit),
    .busy_o        (busy)
  );

  // Captured request
  logic [VEC_W-1:0] vec_q;
  logic             soft_q;
  logic             real_q;
  logic [ERR_W-1:0] code_q;
  logic             pending_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vec_q  <= '0;
      soft_q <= 1'b0;
      real_q <= 1'b0;
      code_q <= '0;
    end else if (capture_req) begin
      vec_q  <= vector;
      soft_q <= sw_int;
      real_q <= real_mode;
      code_q <= err_code;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)       pending_q <= 1'b0;
    else if (capture_old) pending_q <= rd_data[VALID_BIT];
  end

  logic has_err, attach_err;

  evinj_errvec_lut #(
    .VEC_W    (VEC_W),
    .ERR_MASK (ERR_MASK)
  ) u_lut (
    .vec_i     (vec_q),
    .has_err_o (has_err)
  );

  assign attach_err = has_err & ~real_q;

  evinj_word_build #(
    .VEC_W  (VEC_W),
    .WORD_W (WORD_W)
  ) u_build (
    .vec_i        (vec_q),
    .soft_i       (soft_q),
    .attach_err_i (attach_err),
    .word_o       (inj_wdata)
  );

  assign inj_we    = emit & ~pending_q;
  assign err_we    = inj_we & attach_err;
  assign err_wdata = code_q;
  assign done      = emit;
endmodule

// File: rtl/evinj_encoder_chk.sv
module evinj_encoder_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              rd_en,
  input logic [WORD_W-1:0] rd_data,
  input logic              inj_we,
  input logic [WORD_W-1:0] inj_wdata,
  input logic              err_we,
  input logic              done
);
  assert_read_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> rd_en);

  assert_read_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  assert_pending_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inj_we |-> !$past(rd_data[31]));

  assert_type_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inj_we |-> (inj_wdata[10:8] == 3'd3 || inj_wdata[10:8] == 3'd4));

  assert_valid_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inj_we |-> inj_wdata[31]);

  assert_err_with_inj_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_we |-> (inj_we && inj_wdata[11]));

  assert_strobe_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_we || err_we) |-> done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind evinj_encoder evinj_encoder_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .inj_we    (inj_we),
  .inj_wdata (inj_wdata),
  .err_we    (err_we),
  .done      (done)
);

// File: tb/evinj_encoder_test.sv
module evinj_encoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [31:0] old_word;
    logic [7:0]  vec;
    logic        sw;
    logic        rm;
    logic [31:0] code;
    logic        exp_inj_we;
    logic        exp_err_we;
    logic [31:0] exp_word;
  } vec_t;

  localparam int N_VEC = 13;
  localparam vec_t TBL [N_VEC] = '{
    '{32'h0000_0000, 8'd14,  1'b0, 1'b0, 32'h0000_0006, 1'b1, 1'b1, 32'h8000_0B0E}, // R5 page fault
    '{32'h0000_0000, 8'd14,  1'b0, 1'b1, 32'h0000_0006, 1'b1, 1'b0, 32'h8000_030E}, // R6 real mode
    '{32'h0000_0000, 8'h21,  1'b1, 1'b0, 32'h0000_0055, 1'b1, 1'b0, 32'h8000_0421}, // R3 soft int
    '{32'h0000_0000, 8'd13,  1'b1, 1'b0, 32'h0000_1234, 1'b1, 1'b1, 32'h8000_0C0D}, // R5 soft on err vec
    '{32'h0000_0000, 8'd8,   1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1, 32'h8000_0B08}, // R5 low edge
    '{32'h0000_0000, 8'd9,   1'b0, 1'b0, 32'h0000_0077, 1'b1, 1'b0, 32'h8000_0309}, // R7 gap
    '{32'h0000_0000, 8'd21,  1'b0, 1'b0, 32'hDEAD_BEEF, 1'b1, 1'b1, 32'h8000_0B15}, // R5 top edge
    '{32'h0000_0000, 8'd17,  1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b1, 32'h8000_0B11}, // R5
    '{32'h0000_0000, 8'd45,  1'b0, 1'b0, 32'h0000_0099, 1'b1, 1'b0, 32'h8000_032D}, // R7 alias of 13
    '{32'h8000_0305, 8'd14,  1'b0, 1'b0, 32'h0000_0006, 1'b0, 1'b0, 32'h0000_0000}, // R2 pending
    '{32'h7FFF_FFFF, 8'd3,   1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h8000_0403}, // R2 junk, not valid
    '{32'h0000_0000, 8'd10,  1'b0, 1'b0, 32'h0000_00A5, 1'b1, 1'b1, 32'h8000_0B0A}, // R5
    '{32'h0000_0000, 8'hFF,  1'b0, 1'b1, 32'h0000_0001, 1'b1, 1'b0, 32'h8000_03FF}  // R4 R6
  };

  logic        clk, rst_n, start, sw_int, real_mode;
  logic [7:0]  vector;
  logic [31:0] err_code, rd_data, mem_word;
  logic        rd_en, inj_we, err_we, done, busy;
  logic [31:0] inj_wdata, err_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  evinj_encoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vector(vector), .sw_int(sw_int),
    .err_code(err_code), .real_mode(real_mode), .rd_en(rd_en), .rd_data(rd_data),
    .inj_we(inj_we), .inj_wdata(inj_wdata), .err_we(err_we), .err_wdata(err_wdata),
    .done(done), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Register-file model: read data appears the cycle after rd_en.
  always @(posedge clk) if (rd_en) rd_data <= mem_word;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Observed results of one request.
  int          rd_cyc, done_cyc, done_cnt, inj_cyc, err_cyc, inj_cnt;
  logic [31:0] seen_word, seen_code;

  task automatic observe(input int n_cyc, input bit second_start);
    rd_cyc = -1; done_cyc = -1; done_cnt = 0; inj_cyc = -1; err_cyc = -1; inj_cnt = 0;
    seen_word = '0; seen_code = '0;
    for (int n = 1; n <= n_cyc; n++) begin
      @(negedge clk);
      start = (second_start && n == 1);
      if (second_start && n == 1) vector = 8'd13;
      if (rd_en && rd_cyc < 0) rd_cyc = n;
      if (done) begin done_cnt++; if (done_cyc < 0) done_cyc = n; end
      if (inj_we) begin inj_cnt++; inj_cyc = n; seen_word = inj_wdata; end
      if (err_we) begin err_cyc = n; seen_code = err_wdata; end
    end
    start = 1'b0;
  endtask

  task automatic launch(input vec_t e);
    @(negedge clk);
    mem_word  = e.old_word;
    vector    = e.vec;
    sw_int    = e.sw;
    real_mode = e.rm;
    err_code  = e.code;
    start     = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected 0", 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vector = '0; sw_int = 1'b0; real_mode = 1'b0;
    err_code = '0; mem_word = '0; rd_data = '0;
    repeat (3) @(negedge clk);
    // R9: outputs quiet in reset
    chk({rd_en, inj_we, err_we, done, busy} == 5'b0, "R9 in reset",
        {27'b0, rd_en, inj_we, err_we, done, busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rd_en, inj_we, err_we, done, busy} == 5'b0, "R9 after release",
        {27'b0, rd_en, inj_we, err_we, done, busy}, 32'h0);
    repeat (3) @(negedge clk);

    // Table walk
    for (int i = 0; i < N_VEC; i++) begin
      launch(TBL[i]);
      observe(6, 1'b0);
      chk(rd_cyc == 1, $sformatf("R1 read cycle, case %0d", i), rd_cyc, 1);
      chk(done_cyc == 3 && done_cnt == 1, $sformatf("R8 done timing, case %0d", i), done_cyc, 3);
      chk((inj_cnt == 1) == TBL[i].exp_inj_we, $sformatf("R2 inj write, case %0d", i),
          inj_cnt, TBL[i].exp_inj_we);
      if (TBL[i].exp_inj_we) begin
        chk(inj_cyc == 3, $sformatf("R8 strobe with done, case %0d", i), inj_cyc, 3);
        chk(seen_word == TBL[i].exp_word, $sformatf("R4 R3 word, case %0d", i),
            seen_word, TBL[i].exp_word);
      end
      chk((err_cyc >= 0) == TBL[i].exp_err_we, $sformatf("R5 R6 R7 err write, case %0d", i),
          err_cyc, TBL[i].exp_err_we ? 3 : -1);
      if (TBL[i].exp_err_we) begin
        chk(err_cyc == inj_cyc, $sformatf("R5 same cycle, case %0d", i), err_cyc, inj_cyc);
        chk(seen_code == TBL[i].code, $sformatf("R5 err code, case %0d", i), seen_code, TBL[i].code);
      end
    end

    // R8: second start while busy is ignored
    launch('{32'h0, 8'd9, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h8000_0309});
    observe(8, 1'b1);
    chk(done_cnt == 1, "R8 start while busy ignored (done count)", done_cnt, 1);
    chk(inj_cnt == 1 && seen_word == 32'h8000_0309, "R8 start while busy ignored (word)",
        seen_word, 32'h8000_0309);

    // R9: reset in mid-request leaves no strobe behind
    launch('{32'h0, 8'd14, 1'b0, 1'b0, 32'h6, 1'b1, 1'b1, 32'h8000_0B0E});
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    #1;
    chk({rd_en, busy} == 2'b0, "R9 async reset mid-request", {30'b0, rd_en, busy}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    observe(6, 1'b0);
    chk(inj_cnt == 0 && err_cyc < 0 && done_cnt == 0, "R9 no write after reset",
        inj_cnt, 0);

    // Back to normal after reset
    launch('{32'h0, 8'd11, 1'b0, 1'b0, 32'h0000_0BAD, 1'b1, 1'b1, 32'h8000_0B0B});
    observe(6, 1'b0);
    chk(seen_word == 32'h8000_0B0B && seen_code == 32'h0000_0BAD, "R5 vector 11 after reset",
        seen_word, 32'h8000_0B0B);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule